// File: doc/BRIEF.md
# Addressed Two-Stage Pulse-Counting DAC Array

This block holds the programmed state of an array of pulse-loaded DAC channels. Unit pulses arrive on a small number of tree inputs, one per address tree. All trees share one address bus. Each tree is a binary tree of 1:2 steering elements that routes a pulse to exactly one leaf. The two leaves under each leaf pair are the COARSE and FINE stages of one DAC. A sign bit that travels with each pulse says whether the stage count goes up or down.

Each stage keeps a signed count that saturates at a per-channel capacity. A pulse that would cross that capacity is discarded, and the discard latches a sticky overflow flag for the DAC. A per-DAC clear empties both stages and drops the flag. A readback port selects one DAC and returns its weighted value, coarse count times the ratio plus fine count, together with the DAC's flag. Each stage counter decodes its cycle into one of four operations: OP_IDLE, OP_UP, OP_DOWN or OP_CLEAR. Every operation returns to the same single counting state. OP_CLEAR takes priority over any pulse.

Top module: `pulse_dac_array`

## Requirements
- R1: A pulse on tree input t with address A changes only DAC number t*32 + A[5:1]. Every other DAC, including those on the other tree at the same address, keeps its value.
- R2: Address bit A[0] selects the stage: 0 is COARSE and 1 is FINE. rd_value equals coarse*10 + fine as a 12-bit two's complement number.
- R3: With the sign bit at 0 a pulse adds one to the selected stage. With the sign bit at 1 it subtracts one. Counts may go negative.
- R4: Channels 0 to 31 allow counts within ±17 on both stages. Channels 32 to 63 allow ±40 on COARSE and ±10 on FINE. A pulse that would leave that range is dropped, and the count is unchanged.
- R5: A dropped pulse sets rd_ovf for its DAC. A pulse that lands exactly on the limit does not set it. Once set, the flag stays set until that DAC is cleared.
- R6: When clr_en is high at an edge, DAC clr_idx has both stages and its flag at zero after that edge. The clear wins over a pulse aimed at the same DAC in the same cycle.
- R7: After rst_n is asserted low, every DAC reads value 0 with rd_ovf low.
- R8: Both tree inputs may pulse in the same cycle. Each pulse is applied to its own DAC.
- R9: The readback is combinational in rd_idx. A count updated at a clock edge is visible on rd_value right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 2 | One unit pulse per tree, valid for one cycle |
| pulse_dn | input | 2 | Sign per tree: 1 decrements |
| addr | input | 6 | Shared address: [5:1] DAC within tree, [0] stage |
| clr_en | input | 1 | Clear request |
| clr_idx | input | 6 | DAC to clear |
| rd_idx | input | 6 | DAC to read back |
| rd_value | output | 12 | Weighted value of DAC rd_idx |
| rd_ovf | output | 1 | Sticky overflow flag of DAC rd_idx |

## Verification
The assertions take the inputs to be known values at each rising edge and the pulse inputs to be one-cycle levels. They place no other limit on address or sign. The step-size and range properties hold only because a stage sees at most one pulse per cycle. That holds because the shared address picks a single leaf per tree. The bench changes all inputs on the falling edge, so each pulse is taken at one edge, and it reads the outputs before the next rising edge.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_UP    = 2'd1,
        OP_DOWN  = 2'd2,
        OP_CLEAR = 2'd3
    } stage_op_e;

    typedef enum logic {
        STAGE_COARSE = 1'b0,
        STAGE_FINE   = 1'b1
    } stage_sel_e;

endpackage

// File: rtl/pdac_steer_tree.sv
module pdac_steer_tree #(
    parameter int LEVELS = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pulse,
    input  logic [LEVELS-1:0]      sel,
    output logic [(2**LEVELS)-1:0] leaf
);
    localparam int NODES  = (2**(LEVELS+1)) - 1;
    localparam int INNER  = (2**LEVELS) - 1;

    logic [NODES-1:0] node;

    assign node[0] = pulse;

    // each inner node is one 1:2 steering element
    for (genvar i = 0; i < INNER; i++) begin : g_elem
        localparam int DEPTH = $clog2(i + 2) - 1;
        assign node[2*i+1] = node[i] & ~sel[LEVELS-1-DEPTH];
        assign node[2*i+2] = node[i] &  sel[LEVELS-1-DEPTH];
    end

    assign leaf = node[NODES-1:INNER];

    AST_ONE_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $countones(leaf) == 1) else $error("leaf count");   // R1
    AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |-> leaf == '0) else $error("stray leaf");              // R1

endmodule

// File: rtl/pdac_stage.sv
module pdac_stage
    import pdac_pkg::*;
#(
    parameter int CAP   = 17,
    parameter int CNT_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hit,
    input  logic                    dn,
    input  logic                    clr,
    output logic signed [CNT_W-1:0] count,
    output logic                    drop
);
    localparam logic signed [CNT_W-1:0] TOP = CNT_W'(CAP);
    localparam logic signed [CNT_W-1:0] BOT = -TOP;
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    stage_op_e               op;
    logic signed [CNT_W-1:0] nxt;

    always_comb begin
        if (clr)      op = OP_CLEAR;
        else if (hit) op = dn ? OP_DOWN : OP_UP;
        else          op = OP_IDLE;
    end

    always_comb begin
        nxt  = count;
        drop = 1'b0;
        unique case (op)
            OP_IDLE:  nxt = count;
            OP_CLEAR: nxt = '0;
            OP_UP: begin
                if (count == TOP) drop = 1'b1;
                else              nxt  = count + ONE;
            end
            OP_DOWN: begin
                if (count == BOT) drop = 1'b1;
                else              nxt  = count - ONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end

    AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= TOP) && (count >= BOT)) else $error("range");                    // R4
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0) else $error("clear");                                 // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count)) || (count == $past(count) + ONE)
                 || (count == $past(count) - ONE)) else $error("step");            // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hit) |=> $stable(count)) else $error("idle");                    // R1

endmodule

// File: rtl/pdac_channel.sv
module pdac_channel #(
    parameter int C_CAP = 17,
    parameter int F_CAP = 17,
    parameter int GAMMA = 10,
    parameter int CNT_W = 7,
    parameter int VAL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_c,
    input  logic             hit_f,
    input  logic             dn,
    input  logic             clr,
    output logic [VAL_W-1:0] value,
    output logic             ovf
);
    localparam logic signed [VAL_W-1:0] RATIO = VAL_W'(GAMMA);

    logic signed [CNT_W-1:0] cnt_c, cnt_f;
    logic                    drop_c, drop_f;
    logic signed [VAL_W-1:0] ext_c, ext_f;

    pdac_stage #(.CAP(C_CAP), .CNT_W(CNT_W)) u_coarse (
        .clk(clk), .rst_n(rst_n), .hit(hit_c), .dn(dn), .clr(clr),
        .count(cnt_c), .drop(drop_c)
    );

    pdac_stage #(.CAP(F_CAP), .CNT_W(CNT_W)) u_fine (
        .clk(clk), .rst_n(rst_n), .hit(hit_f), .dn(dn), .clr(clr),
        .count(cnt_f), .drop(drop_f)
    );

    always_comb begin
        ext_c = VAL_W'(cnt_c);
        ext_f = VAL_W'(cnt_f);
        value = ext_c * RATIO + ext_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ovf <= 1'b0;
        else if (clr) ovf <= 1'b0;
        else if (drop_c || drop_f) ovf <= 1'b1;
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf) else $error("sticky");         // R5
    AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ovf) else $error("flag clear");              // R6

endmodule

// File: rtl/pulse_dac_array.sv
module pulse_dac_array
    import pdac_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int TREES  = 2,
    parameter int GAMMA  = 10,
    parameter int SMALL_C_CAP = 17,
    parameter int SMALL_F_CAP = 17,
    parameter int LARGE_C_CAP = 40,
    parameter int LARGE_F_CAP = 10,
    parameter int CNT_W  = 7,
    parameter int VAL_W  = 12,
    parameter logic [TREES*(2**(ADDR_W-1))-1:0] LARGE_MASK = {32'hFFFF_FFFF, 32'h0000_0000}
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [TREES-1:0]                           pulse_in,
    input  logic [TREES-1:0]                           pulse_dn,
    input  logic [ADDR_W-1:0]                          addr,
    input  logic                                       clr_en,
    input  logic [$clog2(TREES*(2**(ADDR_W-1)))-1:0]   clr_idx,
    input  logic [$clog2(TREES*(2**(ADDR_W-1)))-1:0]   rd_idx,
    output logic [VAL_W-1:0]                           rd_value,
    output logic                                       rd_ovf
);
    localparam int LEAVES   = 2**ADDR_W;
    localparam int PER_TREE = LEAVES / 2;
    localparam int NUM_DAC  = TREES * PER_TREE;
    localparam int IDX_W    = $clog2(NUM_DAC);

    logic [LEAVES-1:0] leaf_v [TREES];
    logic [VAL_W-1:0]  val_arr [NUM_DAC];
    logic [NUM_DAC-1:0] ovf_arr;

    for (genvar t = 0; t < TREES; t++) begin : g_tree
        pdac_steer_tree #(.LEVELS(ADDR_W)) u_tree (
            .clk(clk), .rst_n(rst_n), .pulse(pulse_in[t]), .sel(addr), .leaf(leaf_v[t])
        );
    end

    for (genvar ch = 0; ch < NUM_DAC; ch++) begin : g_dac
        localparam int T   = ch / PER_TREE;
        localparam int LOC = ch % PER_TREE;
        localparam int CC  = LARGE_MASK[ch] ? LARGE_C_CAP : SMALL_C_CAP;
        localparam int FC  = LARGE_MASK[ch] ? LARGE_F_CAP : SMALL_F_CAP;

        logic clr_here;
        assign clr_here = clr_en && (clr_idx == IDX_W'(ch));

        pdac_channel #(
            .C_CAP(CC), .F_CAP(FC), .GAMMA(GAMMA), .CNT_W(CNT_W), .VAL_W(VAL_W)
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .hit_c(leaf_v[T][2*LOC + int'(STAGE_COARSE)]),
            .hit_f(leaf_v[T][2*LOC + int'(STAGE_FINE)]),
            .dn(pulse_dn[T]), .clr(clr_here),
            .value(val_arr[ch]), .ovf(ovf_arr[ch])
        );
    end

    always_comb begin
        rd_value = val_arr[rd_idx];
        rd_ovf   = ovf_arr[rd_idx];
    end

    AST_RESET_EMPTY: assert property (@(posedge clk)
        $rose(rst_n) |-> (ovf_arr == '0)) else $error("reset flags");   // R7

endmodule

// File: tb/pulse_dac_array_test.sv
module pulse_dac_array_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pulse_in = '0;
    logic [1:0]  pulse_dn = '0;
    logic [5:0]  addr = '0;
    logic        clr_en = 1'b0;
    logic [5:0]  clr_idx = '0;
    logic [5:0]  rd_idx = '0;
    logic [11:0] rd_value;
    logic        rd_ovf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pulse_dac_array uut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .pulse_dn(pulse_dn),
        .addr(addr), .clr_en(clr_en), .clr_idx(clr_idx), .rd_idx(rd_idx),
        .rd_value(rd_value), .rd_ovf(rd_ovf)
    );

    // fields: [26] tree, [25] sign, [24:19] addr, [18:13] read index, [12:1] value, [0] flag
    localparam logic [26:0] VEC [0:9] = '{
        {1'b0, 1'b0, 6'h00, 6'd0,   12'sd10,  1'b0},   // R2 coarse
        {1'b0, 1'b0, 6'h01, 6'd0,   12'sd11,  1'b0},   // R2 fine
        {1'b0, 1'b1, 6'h01, 6'd0,   12'sd10,  1'b0},   // R3 down
        {1'b0, 1'b1, 6'h01, 6'd0,   12'sd9,   1'b0},   // R3 negative fine
        {1'b0, 1'b1, 6'h01, 6'd0,   12'sd8,   1'b0},   // R3
        {1'b1, 1'b1, 6'h00, 6'd32, -12'sd10,  1'b0},   // R1 other tree
        {1'b1, 1'b0, 6'h3F, 6'd63,  12'sd1,   1'b0},   // R1 last leaf
        {1'b0, 1'b0, 6'h0B, 6'd5,   12'sd1,   1'b0},   // R1
        {1'b0, 1'b1, 6'h0A, 6'd5,  -12'sd9,   1'b0},   // R2
        {1'b1, 1'b0, 6'h0B, 6'd5,  -12'sd9,   1'b0}    // R1 tree 1 leaves DAC5 alone
    };

    task automatic chk(input string req, input int idx, input logic [11:0] ev, input logic eo);
        rd_idx = 6'(idx);
        #1;
        total++;
        if (rd_value !== ev || rd_ovf !== eo) begin
            bad++;
            $display("FAIL %s dac=%0d value=%0d ovf=%0b expected value=%0d ovf=%0b",
                     req, idx, $signed(rd_value), rd_ovf, $signed(ev), eo);
        end
    endtask

    task automatic pulse1(input int t, input logic dn, input int a);
        @(negedge clk);
        pulse_in = '0;
        pulse_in[t] = 1'b1;
        pulse_dn[t] = dn;
        addr = 6'(a);
        @(negedge clk);
        pulse_in = '0;
    endtask

    task automatic repeat_pulse(input int t, input logic dn, input int a, input int n);
        for (int i = 0; i < n; i++) pulse1(t, dn, a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", 0, 12'd0, 1'b0);
        chk("R7", 63, 12'd0, 1'b0);
        chk("R7", 33, 12'd0, 1'b0);

        for (int k = 0; k < 10; k++) begin
            pulse1(int'(VEC[k][26]), VEC[k][25], int'(VEC[k][24:19]));
            chk("R1/R2/R3 vector", int'(VEC[k][18:13]), VEC[k][12:1], VEC[k][0]);
        end

        // R9: readback follows rd_idx without a clock edge
        chk("R9", 32, -12'sd10, 1'b0);
        chk("R9", 0, 12'sd8, 1'b0);

        // R4 small coarse limit on DAC 2 (addr 4)
        repeat_pulse(0, 1'b0, 4, 17);
        chk("R4", 2, 12'sd170, 1'b0);
        pulse1(0, 1'b0, 4);
        chk("R5", 2, 12'sd170, 1'b1);
        repeat_pulse(0, 1'b1, 4, 34);
        chk("R4", 2, -12'sd170, 1'b1);
        pulse1(0, 1'b1, 4);
        chk("R4", 2, -12'sd170, 1'b1);

        // R4 small fine limit on DAC 3 (addr 7)
        repeat_pulse(0, 1'b0, 7, 17);
        chk("R5", 3, 12'sd17, 1'b0);
        pulse1(0, 1'b0, 7);
        chk("R4", 3, 12'sd17, 1'b1);

        // R4 large limits on DAC 40 (addr 16/17) and DAC 41 (addr 19)
        repeat_pulse(1, 1'b0, 16, 40);
        chk("R4", 40, 12'sd400, 1'b0);
        pulse1(1, 1'b0, 16);
        chk("R5", 40, 12'sd400, 1'b1);
        repeat_pulse(1, 1'b0, 17, 11);
        chk("R4", 40, 12'sd410, 1'b1);
        repeat_pulse(1, 1'b0, 19, 10);
        chk("R5", 41, 12'sd10, 1'b0);
        pulse1(1, 1'b0, 19);
        chk("R4", 41, 12'sd10, 1'b1);

        // R6 clear of DAC 2, neighbour DAC 3 untouched
        @(negedge clk);
        clr_en = 1'b1; clr_idx = 6'd2;
        @(negedge clk);
        clr_en = 1'b0;
        chk("R6", 2, 12'd0, 1'b0);
        chk("R6", 3, 12'sd17, 1'b1);

        // R6 clear beats a pulse to the same DAC
        @(negedge clk);
        clr_en = 1'b1; clr_idx = 6'd0;
        pulse_in = 2'b01; pulse_dn = 2'b00; addr = 6'h00;
        @(negedge clk);
        clr_en = 1'b0; pulse_in = '0;
        chk("R6", 0, 12'd0, 1'b0);

        // R8 both trees in one cycle, shared address 0x14
        @(negedge clk);
        pulse_in = 2'b11; pulse_dn = 2'b10; addr = 6'h14;
        @(negedge clk);
        pulse_in = '0;
        chk("R8", 10, 12'sd10, 1'b0);
        chk("R8", 42, -12'sd10, 1'b0);

        // R7 reset mid-run empties everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R7", 40, 12'd0, 1'b0);
        chk("R7", 3, 12'd0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired value=%0d expected completion", rd_value);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule